// File: doc/BRIEF.md
# I2C Transaction Command Sequencer

This block converts a single I2C transfer descriptor into the ordered series of 16-bit command words that a command-driven I2C master FIFO consumes. A descriptor gives a 7-bit target address, a read/write direction, an optional subaddress of up to four bytes, a payload length, and two flags. One flag suppresses the opening START. The other suppresses the closing STOP. Words leave on a valid/ready handshake.

The block works out the direction of the opening START from two facts: whether a subaddress is present, and the direction of the transfer. It inserts a repeated START only when a write phase has to turn into a read. Long reads are split into several receive commands. A count of the words that come before the payload is reported when the descriptor is accepted. A companion engine moves the payload itself and signals the end of that phase with `data_done_i`. After that, the sequencer closes the transfer with a STOP word unless the no-stop flag is set.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset `cmd_valid_o`, `busy_o`, `done_o` and `busy_err_o` are 0 and `word_count_o` is 0.
- R2: The opening START word is `0x0400 | (addr << 1) | d`. Here d is 0 (write) whenever the subaddress size is nonzero, and otherwise it is the transfer direction (1 = read).
- R3: Subaddress bytes follow the START as transmit words `0x00bb`, one per byte of the given size, most significant byte first.
- R4: A read of nonzero length that has a subaddress emits a repeated START `0x0400 | (addr << 1) | 1` after the subaddress bytes. No other transfer emits a repeated START.
- R5: A read of nonzero length emits receive words `0x01nn`, where nn is the chunk size minus one. Chunks of RX_CHUNK bytes (256) come first, and the last chunk takes the remainder.
- R6: With no-start set, a read of nonzero length emits only its receive words, and a write emits no pre-payload words.
- R7: With no-start set and zero length, no word at all is emitted, no STOP either. `done_o` pulses in the cycle after acceptance.
- R8: After the pre-payload words of a nonzero-length transfer, no word is offered until `data_done_i` is seen. Then STOP `0x0200` is emitted unless no-stop is set. A zero-length transfer with a START goes straight to the STOP.
- R9: `done_o` pulses for one cycle after the last word or the payload end, and `busy_o` is 0 in that cycle.
- R10: From the cycle after acceptance, `word_count_o` holds the number of pre-payload words, STOP excluded, and it stays stable while busy.
- R11: A `start_i` while busy raises `busy_err_o` for one cycle and leaves the running transfer unchanged.
- R12: While `cmd_valid_o` is high and `cmd_ready_i` low, `cmd_word_o` and `cmd_valid_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Accept the descriptor on the inputs below |
| tgt_addr_i | input | 7 | Target address |
| dir_read_i | input | 1 | 1 = read, 0 = write |
| sub_size_i | input | SUB_SZ_W | Subaddress byte count, 0..SUB_BYTES |
| sub_addr_i | input | 8*SUB_BYTES | Subaddress value, right-aligned |
| len_i | input | LEN_W | Payload length in bytes |
| no_start_i | input | 1 | Omit START and subaddress |
| no_stop_i | input | 1 | Omit closing STOP |
| data_done_i | input | 1 | Payload phase finished |
| cmd_valid_o | output | 1 | Command word offered |
| cmd_ready_i | input | 1 | FIFO takes the word |
| cmd_word_o | output | 16 | Command word, code in 15:8, data in 7:0 |
| word_count_o | output | LEN_W+1 | Pre-payload word count |
| busy_o | output | 1 | Transfer in progress |
| busy_err_o | output | 1 | Start rejected while busy |
| done_o | output | 1 | Transfer finished |

## Verification
The bench builds the block with its default parameters: a 16-bit length, a four-byte subaddress and 256-byte receive chunks. With these values, a 600-byte read splits into three receive words, a read of exactly 256 bytes stays at one word, and a full four-byte subaddress reaches every byte-select branch. Ready is throttled by a pseudo-random pattern, so words are held under back-pressure. A rejected start is issued in the middle of a repeated-start read.

// File: rtl/i2c_cmd_seq_pkg.sv
package i2c_cmd_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SUB,
        ST_RSTART,
        ST_RECV,
        ST_WAIT,
        ST_STOP
    } seq_state_e;

    localparam logic [7:0] CODE_TX    = 8'h00;
    localparam logic [7:0] CODE_RX    = 8'h01;
    localparam logic [7:0] CODE_STOP  = 8'h02;
    localparam logic [7:0] CODE_START = 8'h04;
endpackage

// File: rtl/i2c_cmd_count.sv
module i2c_cmd_count #(
    parameter int LEN_W    = 16,
    parameter int SUB_SZ_W = 3,
    parameter int RX_CHUNK = 256,
    localparam int CNT_W   = LEN_W + 1,
    localparam int CHUNK_SH = $clog2(RX_CHUNK)
) (
    input  logic                dir_read,
    input  logic                no_start,
    input  logic [SUB_SZ_W-1:0] sub_size,
    input  logic [LEN_W-1:0]    len,
    output logic [CNT_W-1:0]    count
);
    logic [LEN_W:0] n_rx;
    logic           has_rd;

    always_comb begin
        has_rd = dir_read && (len != '0);
        n_rx   = ({1'b0, len} + (LEN_W+1)'(RX_CHUNK - 1)) >> CHUNK_SH;
        if (no_start) begin
            count = has_rd ? CNT_W'(n_rx) : '0;
        end else begin
            count = CNT_W'(1) + CNT_W'(sub_size);
            if (has_rd) begin
                count = count + CNT_W'(n_rx) + ((sub_size != '0) ? CNT_W'(1) : '0);
            end
        end
    end
endmodule

// File: rtl/i2c_cmd_word_gen.sv
module i2c_cmd_word_gen
    import i2c_cmd_seq_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int SUB_BYTES = 4,
    parameter int SUB_SZ_W  = 3,
    parameter int RX_CHUNK  = 256
) (
    input  seq_state_e             state,
    input  logic [6:0]             addr,
    input  logic                   dir_read,
    input  logic                   has_sub,
    input  logic [8*SUB_BYTES-1:0] sub_addr,
    input  logic [SUB_SZ_W-1:0]    sub_rem,
    input  logic [LEN_W-1:0]       rx_rem,
    output logic                   emit,
    output logic [15:0]            word
);
    localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(RX_CHUNK);

    logic [7:0]       code;
    logic [7:0]       data;
    logic [LEN_W-1:0] chunk_m1;

    always_comb begin
        code     = CODE_TX;
        data     = '0;
        emit     = 1'b1;
        chunk_m1 = (rx_rem >= CHUNK_L) ? (CHUNK_L - LEN_W'(1)) : (rx_rem - LEN_W'(1));
        case (state)
            ST_START: begin
                code = CODE_START;
                data = {addr, has_sub ? 1'b0 : dir_read};
            end
            ST_SUB: begin
                code = CODE_TX;
                for (int i = 0; i < SUB_BYTES; i++) begin
                    if (sub_rem == SUB_SZ_W'(i + 1)) data = sub_addr[8*i +: 8];
                end
            end
            ST_RSTART: begin
                code = CODE_START;
                data = {addr, 1'b1};
            end
            ST_RECV: begin
                code = CODE_RX;
                data = chunk_m1[7:0];
            end
            ST_STOP: begin
                code = CODE_STOP;
            end
            default: emit = 1'b0;
        endcase
        word = {code, data};
    end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2c_cmd_seq_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int SUB_BYTES = 4,
    parameter int RX_CHUNK  = 256,
    localparam int SUB_SZ_W = $clog2(SUB_BYTES + 1),
    localparam int CNT_W    = LEN_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [6:0]             tgt_addr_i,
    input  logic                   dir_read_i,
    input  logic [SUB_SZ_W-1:0]    sub_size_i,
    input  logic [8*SUB_BYTES-1:0] sub_addr_i,
    input  logic [LEN_W-1:0]       len_i,
    input  logic                   no_start_i,
    input  logic                   no_stop_i,
    input  logic                   data_done_i,
    output logic                   cmd_valid_o,
    input  logic                   cmd_ready_i,
    output logic [15:0]            cmd_word_o,
    output logic [CNT_W-1:0]       word_count_o,
    output logic                   busy_o,
    output logic                   busy_err_o,
    output logic                   done_o
);
    localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(RX_CHUNK);

    typedef struct packed {
        seq_state_e             st;
        logic [6:0]             addr;
        logic                   rd;
        logic [SUB_SZ_W-1:0]    sub_sz;
        logic [SUB_SZ_W-1:0]    sub_rem;
        logic [8*SUB_BYTES-1:0] sub_addr;
        logic [LEN_W-1:0]       len;
        logic [LEN_W-1:0]       rx_rem;
        logic                   no_stop;
        logic [CNT_W-1:0]       count;
        logic                   done;
        logic                   err;
    } seq_regs_t;

    seq_regs_t        q, d;
    logic             emit;
    logic             fire;
    logic [CNT_W-1:0] count_in;
    seq_state_e       post_sub;
    logic             post_done;

    i2c_cmd_count #(
        .LEN_W(LEN_W), .SUB_SZ_W(SUB_SZ_W), .RX_CHUNK(RX_CHUNK)
    ) u_count (
        .dir_read (dir_read_i),
        .no_start (no_start_i),
        .sub_size (sub_size_i),
        .len      (len_i),
        .count    (count_in)
    );

    i2c_cmd_word_gen #(
        .LEN_W(LEN_W), .SUB_BYTES(SUB_BYTES), .SUB_SZ_W(SUB_SZ_W), .RX_CHUNK(RX_CHUNK)
    ) u_word (
        .state    (q.st),
        .addr     (q.addr),
        .dir_read (q.rd),
        .has_sub  (q.sub_sz != '0),
        .sub_addr (q.sub_addr),
        .sub_rem  (q.sub_rem),
        .rx_rem   (q.rx_rem),
        .emit     (emit),
        .word     (cmd_word_o)
    );

    assign fire = emit && cmd_ready_i;

    // Where the sequence goes once the address phase is over.
    always_comb begin
        post_done = 1'b0;
        if (q.rd && (q.len != '0)) begin
            post_sub = (q.sub_sz != '0) ? ST_RSTART : ST_RECV;
        end else if (q.len != '0) begin
            post_sub = ST_WAIT;
        end else if (q.no_stop) begin
            post_sub  = ST_IDLE;
            post_done = 1'b1;
        end else begin
            post_sub = ST_STOP;
        end
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = start_i && (q.st != ST_IDLE);
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.addr     = tgt_addr_i;
                    d.rd       = dir_read_i;
                    d.sub_sz   = no_start_i ? '0 : sub_size_i;
                    d.sub_rem  = no_start_i ? '0 : sub_size_i;
                    d.sub_addr = sub_addr_i;
                    d.len      = len_i;
                    d.rx_rem   = len_i;
                    d.no_stop  = no_stop_i;
                    d.count    = count_in;
                    if (!no_start_i) begin
                        d.st = ST_START;
                    end else if (dir_read_i && (len_i != '0)) begin
                        d.st = ST_RECV;
                    end else if (len_i != '0) begin
                        d.st = ST_WAIT;
                    end else begin
                        d.done = 1'b1;
                    end
                end
            end
            ST_START: begin
                if (fire) begin
                    if (q.sub_sz != '0) begin
                        d.st = ST_SUB;
                    end else begin
                        d.st   = post_sub;
                        d.done = post_done;
                    end
                end
            end
            ST_SUB: begin
                if (fire) begin
                    d.sub_rem = q.sub_rem - SUB_SZ_W'(1);
                    if (q.sub_rem == SUB_SZ_W'(1)) begin
                        d.st   = post_sub;
                        d.done = post_done;
                    end
                end
            end
            ST_RSTART: begin
                if (fire) d.st = ST_RECV;
            end
            ST_RECV: begin
                if (fire) begin
                    if (q.rx_rem <= CHUNK_L) begin
                        d.rx_rem = '0;
                        d.st     = ST_WAIT;
                    end else begin
                        d.rx_rem = q.rx_rem - CHUNK_L;
                    end
                end
            end
            ST_WAIT: begin
                if (data_done_i) begin
                    if (q.no_stop) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st = ST_STOP;
                    end
                end
            end
            ST_STOP: begin
                if (fire) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_valid_o  = emit;
    assign word_count_o = q.count;
    assign busy_o       = (q.st != ST_IDLE);
    assign busy_err_o   = q.err;
    assign done_o       = q.done;
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk #(
    parameter int CNT_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             cmd_valid_o,
    input logic             cmd_ready_i,
    input logic [15:0]      cmd_word_o,
    input logic [CNT_W-1:0] word_count_o,
    input logic             busy_o,
    input logic             busy_err_o,
    input logic             done_o
);
    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_word_o))); // R12
    AST_ERR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_err_o |-> $past(start_i && busy_o)); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> busy_o); // R1
    AST_COUNT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(word_count_o)); // R10
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_ready_i  (cmd_ready_i),
    .cmd_word_o   (cmd_word_o),
    .word_count_o (word_count_o),
    .busy_o       (busy_o),
    .busy_err_o   (busy_err_o),
    .done_o       (done_o)
);

// File: tb/i2c_cmd_seq_bench.sv
module i2c_cmd_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 16;
    localparam int SUB_BYTES  = 4;
    localparam int SUB_SZ_W   = 3;
    localparam int CNT_W      = LEN_W + 1;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start_i = 1'b0;
    logic [6:0]             tgt_addr_i = '0;
    logic                   dir_read_i = 1'b0;
    logic [SUB_SZ_W-1:0]    sub_size_i = '0;
    logic [8*SUB_BYTES-1:0] sub_addr_i = '0;
    logic [LEN_W-1:0]       len_i = '0;
    logic                   no_start_i = 1'b0;
    logic                   no_stop_i = 1'b0;
    logic                   data_done_i = 1'b0;
    logic                   cmd_valid_o;
    logic                   cmd_ready_i = 1'b0;
    logic [15:0]            cmd_word_o;
    logic [CNT_W-1:0]       word_count_o;
    logic                   busy_o;
    logic                   busy_err_o;
    logic                   done_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_cmd_seq u_i2c_cmd_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_addr_i(tgt_addr_i),
        .dir_read_i(dir_read_i), .sub_size_i(sub_size_i), .sub_addr_i(sub_addr_i),
        .len_i(len_i), .no_start_i(no_start_i), .no_stop_i(no_stop_i),
        .data_done_i(data_done_i), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
        .cmd_word_o(cmd_word_o), .word_count_o(word_count_o), .busy_o(busy_o),
        .busy_err_o(busy_err_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run_xfer(input int addr, input bit rd, input int ssz, input int sub,
                            input int len, input bit nost, input bit nosp, input bit poke);
        int    exp_w[$];
        string exp_r[$];
        int    npre;
        int    rem;
        int    c;
        int    used;
        int    cyc;
        bit    given;
        bit    poked;
        bit    seen_done;
        // reference model: expected word stream
        if (!nost) begin
            exp_w.push_back(32'h0400 | (addr << 1) | ((ssz != 0) ? 0 : int'(rd)));
            exp_r.push_back("R2");
            for (int i = ssz - 1; i >= 0; i--) begin
                exp_w.push_back((sub >> (8*i)) & 8'hFF);
                exp_r.push_back("R3");
            end
            if (rd && len != 0 && ssz != 0) begin
                exp_w.push_back(32'h0400 | (addr << 1) | 1);
                exp_r.push_back("R4");
            end
        end
        if (rd && len != 0) begin
            rem = len;
            while (rem > 0) begin
                c = (rem > 256) ? 256 : rem;
                exp_w.push_back(32'h0100 | (c - 1));
                exp_r.push_back(nost ? "R6" : "R5");
                rem -= c;
            end
        end
        npre = exp_w.size();
        if (!nosp && !(nost && len == 0)) begin
            exp_w.push_back(32'h0200);
            exp_r.push_back("R8");
        end
        // issue descriptor
        @(negedge clk);
        tgt_addr_i = addr[6:0]; dir_read_i = rd; sub_size_i = ssz[SUB_SZ_W-1:0];
        sub_addr_i = sub; len_i = len[LEN_W-1:0]; no_start_i = nost; no_stop_i = nosp;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (nost && len == 0) begin
            check(done_o == 1'b1, "R7 done", int'(done_o), 1);
            check(busy_o == 1'b0 && cmd_valid_o == 1'b0, "R7 no words", int'(cmd_valid_o), 0);
            check(word_count_o == '0, "R7 count", int'(word_count_o), 0);
            return;
        end
        check(busy_o == 1'b1, "R10 busy", int'(busy_o), 1);
        check(int'(word_count_o) == npre, "R10 count", int'(word_count_o), npre);
        used = 0; given = 0; poked = 0; seen_done = 0;
        for (cyc = 0; cyc < 3000; cyc++) begin
            data_done_i = 1'b0;
            start_i     = 1'b0;
            if (poked && cyc > 0) begin end
            if (done_o) begin
                seen_done = 1;
                break;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (cmd_valid_o) begin
                if (used >= exp_w.size()) begin
                    check(1'b0, "R8 extra word", int'(cmd_word_o), 0);
                    cmd_ready_i = 1'b1;
                end else begin
                    if (used == npre && len != 0 && !given)
                        check(1'b0, "R8 word before payload end", int'(cmd_word_o), 0);
                    check(int'(cmd_word_o) == exp_w[used], exp_r[used], int'(cmd_word_o), exp_w[used]);
                    cmd_ready_i = lfsr[0] | lfsr[3];
                    if (cmd_ready_i) used++;
                end
            end else begin
                cmd_ready_i = lfsr[1];
            end
            if (!given && len != 0 && used == npre && !(cmd_valid_o && cmd_ready_i) && lfsr[2]) begin
                data_done_i = 1'b1;
                given = 1;
            end
            if (poke && !poked && used == 1) begin
                start_i = 1'b1;
                poked = 1;
                @(negedge clk);
                start_i = 1'b0;
                check(busy_err_o == 1'b1, "R11 busy error", int'(busy_err_o), 1);
                check(busy_o == 1'b1, "R11 still busy", int'(busy_o), 1);
                continue;
            end
            @(negedge clk);
        end
        cmd_ready_i = 1'b0;
        data_done_i = 1'b0;
        check(seen_done, "R9 done seen (watchdog)", int'(seen_done), 1);
        check(used == exp_w.size(), "R9 all words", used, exp_w.size());
        check(busy_o == 1'b0, "R9 idle at done", int'(busy_o), 0);
        @(negedge clk);
        check(done_o == 1'b0, "R9 single pulse", int'(done_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 2.5);
        check(cmd_valid_o == 1'b0 && busy_o == 1'b0, "R1 reset valid/busy", int'(busy_o), 0);
        check(done_o == 1'b0 && busy_err_o == 1'b0, "R1 reset flags", int'(done_o), 0);
        check(word_count_o == '0, "R1 reset count", int'(word_count_o), 0);
        rst_n = 1'b1;
        // R2 R3: write with 2-byte subaddress
        run_xfer(7'h50, 0, 2, 32'h1234, 3, 0, 0, 0);
        // R4 R5 R11: read through a subaddress, start poked while busy
        run_xfer(7'h1D, 1, 1, 32'h00A5, 4, 0, 0, 1);
        // R2 R8: read without subaddress, no stop
        run_xfer(7'h7F, 1, 0, 0, 1, 0, 1, 0);
        // R5: long read split into chunks
        run_xfer(7'h22, 1, 0, 0, 600, 0, 0, 0);
        // R5: exactly one full chunk
        run_xfer(7'h33, 1, 2, 32'hBEEF, 256, 0, 0, 0);
        // R6: no-start read
        run_xfer(7'h11, 1, 0, 0, 5, 1, 0, 0);
        // R6: no-start write
        run_xfer(7'h11, 0, 0, 0, 2, 1, 0, 0);
        // R7: no-start zero length
        run_xfer(7'h11, 0, 0, 0, 0, 1, 0, 0);
        // R3 R8: full 4-byte subaddress, zero length goes straight to STOP
        run_xfer(7'h2A, 0, 4, 32'hA1B2C3D4, 0, 0, 0, 0);
        // R8: zero-length read without subaddress, no stop
        run_xfer(7'h05, 1, 0, 0, 0, 0, 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule